// File: doc/BRIEF.md
# PCI DMA Window Address Translator

This block turns an address seen on a PCI bus during device DMA into a system memory address. Four programmable windows are held on static register inputs. Each window has a base value, a size mask and a translated base. A window covers part of the bus address space; the upper twelve bits of the 32-bit window field are compared under a mask. A window either maps its range straight onto a region of memory (direct mode) or looks the page up in a single-level table held in memory (scatter-gather mode).

A translation is offered on a valid/ready request port and answered by a one-cycle response pulse. Direct translations and untranslated addresses come back on the cycle after acceptance. A scatter-gather translation builds the address of a 64-bit table entry, fetches it through a memory read port with its own valid/ready request and valid response, and assembles the result from the returned entry. Only one translation is in flight at a time.

Top module: `dwx_xlate`

## Requirements
- R1: Windows are tried from index 0 upward; the lowest-numbered window that both matches and is enabled supplies the translation, even when a higher window also matches.
- R2: A window matches when the bus address and the window base are equal on every bit from 31 down to 20 whose mask bit is 0; mask bits set to 1 exclude that bit from the compare, and bits outside 31:20 never take part.
- R3: Bit 0 of a window base enables the window; a matching window with bit 0 clear is skipped and the search goes on to the next window.
- R4: With base bit 1 clear (direct mode) the result takes bus address bits 19:0, plus each bus bit in 31:20 whose mask bit is 1; every other bit comes from the translated base.
- R5: With base bit 1 set (scatter-gather mode) the entry address has bits 2:0 zero, bits 9:3 equal to bus bits 19:13, each bit k in 21:10 equal to bus bit k+10 when mask bit k+10 is 1 and to translated-base bit k otherwise, and bits 63:22 from the translated base; it is held on the read request until the request is taken.
- R6: The scatter-gather result is bus address bits 12:0 in bits 12:0 and returned entry bits 21:1 in result bits 33:13 (entry bit 0 is discarded).
- R7: Every translated result, direct or scatter-gather, is limited to 34 bits; result bits 63:34 are zero whatever the bus or translated base hold there.
- R8: When no enabled window matches, the response carries the full 64-bit bus address unchanged.
- R9: A direct or untranslated response is valid in the cycle after the request is accepted; a scatter-gather response is valid in the cycle after the entry read response arrives.
- R10: Request ready is low from acceptance of a scatter-gather request until its result is returned, and an entry read response that arrives while no entry read is outstanding has no effect.
- R11: After reset request ready is high and no response and no entry read request is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| win_base_i | input | NUM_WIN*64 | Window base per window: bit 0 enable, bit 1 scatter-gather, bits 31:20 compare value |
| win_mask_i | input | NUM_WIN*64 | Window size mask per window; bits 31:20 used |
| win_xbase_i | input | NUM_WIN*64 | Translated base (direct) or table base (scatter-gather) per window |
| req_valid_i | input | 1 | Translation request valid |
| req_ready_o | output | 1 | Translation request accepted when high with valid |
| req_addr_i | input | 64 | Bus address to translate |
| rsp_valid_o | output | 1 | One-cycle result valid pulse |
| rsp_addr_o | output | 64 | Translated or passed-through address |
| pte_req_valid_o | output | 1 | Table entry read request valid |
| pte_req_ready_i | input | 1 | Table entry read request taken |
| pte_req_addr_o | output | 64 | Table entry address |
| pte_rsp_valid_i | input | 1 | Table entry read data valid |
| pte_rsp_data_i | input | 64 | Table entry read data |

## Verification
The bench aims at overlapping windows, where a design that searched from the top or took a disabled window would return the wrong window's translation, and at addresses differing from a window base only in a compare bit, which a design with an inverted or shifted mask would wrongly translate. Bus addresses and translated bases with upper bits set expose a missing 34-bit limit, while pass-through cases check that the full 64 bits come back untouched. Scatter-gather requests with delayed read acceptance and data, followed at once by a direct request, show whether the entry address is built from the right bits, whether the request port is closed during the fetch, and whether a stray entry response outside a fetch produces a spurious result.

// File: rtl/dwx_pkg.sv
package dwx_pkg;

  localparam int unsigned ADDR_W     = 64;
  localparam int unsigned WIN_LSB    = 20;
  localparam int unsigned WIN_MSB    = 31;
  localparam int unsigned IDX_LSB    = 13;
  localparam int unsigned IDX_W      = 7;
  localparam int unsigned PTE_SHIFT  = 10;
  localparam int unsigned PAGE_SHIFT = 12;
  localparam int unsigned OFF_W      = 13;

  typedef logic [ADDR_W-1:0] dwx_word_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2
  } dwx_state_e;

  localparam dwx_word_t ONE_W       = dwx_word_t'(1);
  localparam dwx_word_t WIN_FIELD   = ((ONE_W << (WIN_MSB - WIN_LSB + 1)) - ONE_W) << WIN_LSB;
  localparam dwx_word_t DIRECT_KEEP = (ONE_W << WIN_LSB) - ONE_W;
  localparam dwx_word_t IDX_FIELD   = ((ONE_W << IDX_W) - ONE_W) << IDX_LSB;
  localparam dwx_word_t TBL_LOW     = (ONE_W << PTE_SHIFT) - ONE_W;
  localparam dwx_word_t PAGE_OFF    = (ONE_W << OFF_W) - ONE_W;

  // Window-size bits taken from the mask register
  function automatic dwx_word_t dwx_size_bits(dwx_word_t mask);
    return mask & WIN_FIELD;
  endfunction

  // Masked compare of bus address against window base
  function automatic logic dwx_win_hit(dwx_word_t bus, dwx_word_t base, dwx_word_t mask);
    dwx_word_t cmp;
    cmp = ~mask & WIN_FIELD;
    return ((bus ^ base) & cmp) == '0;
  endfunction

  // Direct-mapped translation before the physical limit
  function automatic dwx_word_t dwx_direct(dwx_word_t bus, dwx_word_t mask, dwx_word_t xbase);
    dwx_word_t pass;
    pass = dwx_size_bits(mask) | DIRECT_KEEP;
    return (xbase & ~pass) | (bus & pass);
  endfunction

  // Address of the table entry for a scatter-gather window
  function automatic dwx_word_t dwx_pte_addr(dwx_word_t bus, dwx_word_t mask, dwx_word_t xbase);
    dwx_word_t hi_keep;
    dwx_word_t lo_sel;
    hi_keep = ~((dwx_size_bits(mask) >> PTE_SHIFT) | TBL_LOW);
    lo_sel  = dwx_size_bits(mask) | IDX_FIELD;
    return (xbase & hi_keep) | ((bus & lo_sel) >> PTE_SHIFT);
  endfunction

  // Result built from a returned table entry
  function automatic dwx_word_t dwx_sg_result(dwx_word_t pte, dwx_word_t bus);
    return ((pte & ~ONE_W) << PAGE_SHIFT) | (bus & PAGE_OFF);
  endfunction

  // Limit an address to the physical width
  function automatic dwx_word_t dwx_trunc(dwx_word_t a, int unsigned aw);
    dwx_word_t keep;
    keep = ~dwx_word_t'(0);
    keep = keep >> (ADDR_W - aw);
    return a & keep;
  endfunction

endpackage

// File: rtl/dwx_win_match.sv
module dwx_win_match
  import dwx_pkg::*;
#(
  parameter int unsigned NUM_WIN = 4
) (
  input  logic [ADDR_W-1:0]         bus_i,
  input  logic [NUM_WIN*ADDR_W-1:0] base_i,
  input  logic [NUM_WIN*ADDR_W-1:0] mask_i,
  output logic [NUM_WIN-1:0]        match_o,
  output logic [NUM_WIN-1:0]        en_o,
  output logic [NUM_WIN-1:0]        sg_o
);

  for (genvar g = 0; g < NUM_WIN; g++) begin : g_win
    dwx_word_t base_w;
    dwx_word_t mask_w;
    assign base_w     = base_i[g*ADDR_W +: ADDR_W];
    assign mask_w     = mask_i[g*ADDR_W +: ADDR_W];
    assign match_o[g] = dwx_win_hit(bus_i, base_w, mask_w);
    assign en_o[g]    = base_w[0];
    assign sg_o[g]    = base_w[1];
  end

endmodule

// File: rtl/dwx_prio_pick.sv
module dwx_prio_pick #(
  parameter int unsigned N = 4
) (
  input  logic [N-1:0] req_i,
  output logic [N-1:0] grant_o,
  output logic         any_o
);

  always_comb begin
    logic found;
    found   = 1'b0;
    grant_o = '0;
    for (int i = 0; i < N; i++) begin
      if (req_i[i] && !found) begin
        found      = 1'b1;
        grant_o[i] = 1'b1;
      end
    end
    any_o = found;
  end

endmodule

// File: rtl/dwx_ctrl.sv
module dwx_ctrl
  import dwx_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid_i,
  input  logic sg_sel_i,
  input  logic pte_req_ready_i,
  input  logic pte_rsp_valid_i,
  output logic req_ready_o,
  output logic pte_req_valid_o,
  output logic fire_imm_o,
  output logic fire_sg_o,
  output logic pte_done_o
);

  dwx_state_e state_q, state_d;
  logic       fire;

  assign req_ready_o     = (state_q == ST_IDLE);
  assign pte_req_valid_o = (state_q == ST_ISSUE);
  assign fire            = req_valid_i & req_ready_o;
  assign fire_sg_o       = fire & sg_sel_i;
  assign fire_imm_o      = fire & ~sg_sel_i;
  assign pte_done_o      = (state_q == ST_WAIT) & pte_rsp_valid_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (fire_sg_o)       state_d = ST_ISSUE;
      ST_ISSUE: if (pte_req_ready_i) state_d = ST_WAIT;
      ST_WAIT:  if (pte_rsp_valid_i) state_d = ST_IDLE;
      default:                       state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

endmodule

// File: rtl/dwx_xlate.sv
module dwx_xlate
  import dwx_pkg::*;
#(
  parameter int unsigned NUM_WIN = 4,
  parameter int unsigned PHYS_AW = 34
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM_WIN*ADDR_W-1:0] win_base_i,
  input  logic [NUM_WIN*ADDR_W-1:0] win_mask_i,
  input  logic [NUM_WIN*ADDR_W-1:0] win_xbase_i,
  input  logic                      req_valid_i,
  output logic                      req_ready_o,
  input  logic [ADDR_W-1:0]         req_addr_i,
  output logic                      rsp_valid_o,
  output logic [ADDR_W-1:0]         rsp_addr_o,
  output logic                      pte_req_valid_o,
  input  logic                      pte_req_ready_i,
  output logic [ADDR_W-1:0]         pte_req_addr_o,
  input  logic                      pte_rsp_valid_i,
  input  logic [ADDR_W-1:0]         pte_rsp_data_i
);

  // Named internal events, observed by the bound checker
  logic [NUM_WIN-1:0] win_match;
  logic [NUM_WIN-1:0] win_en;
  logic [NUM_WIN-1:0] win_sg;
  logic [NUM_WIN-1:0] win_grant;
  logic               any_hit;
  logic               sg_sel;
  logic               fire_imm;
  logic               fire_sg;
  logic               pte_done;
  logic               rsp_xlat;

  dwx_word_t sel_mask, sel_xbase;
  dwx_word_t imm_res, sg_res, pte_addr_nxt;
  dwx_word_t pte_addr_q, bus_q;

  dwx_win_match #(.NUM_WIN(NUM_WIN)) u_match (
    .bus_i   (req_addr_i),
    .base_i  (win_base_i),
    .mask_i  (win_mask_i),
    .match_o (win_match),
    .en_o    (win_en),
    .sg_o    (win_sg)
  );

  dwx_prio_pick #(.N(NUM_WIN)) u_pick (
    .req_i   (win_match & win_en),
    .grant_o (win_grant),
    .any_o   (any_hit)
  );

  // One-hot AND-OR select of the granted window's registers
  always_comb begin
    sel_mask  = '0;
    sel_xbase = '0;
    for (int i = 0; i < NUM_WIN; i++) begin
      sel_mask  |= win_grant[i] ? win_mask_i[i*ADDR_W +: ADDR_W]  : '0;
      sel_xbase |= win_grant[i] ? win_xbase_i[i*ADDR_W +: ADDR_W] : '0;
    end
  end

  assign sg_sel       = any_hit & |(win_grant & win_sg);
  assign imm_res      = any_hit ? dwx_trunc(dwx_direct(req_addr_i, sel_mask, sel_xbase), PHYS_AW)
                                : req_addr_i;
  assign pte_addr_nxt = dwx_pte_addr(req_addr_i, sel_mask, sel_xbase);
  assign sg_res       = dwx_trunc(dwx_sg_result(pte_rsp_data_i, bus_q), PHYS_AW);

  dwx_ctrl u_ctrl (
    .clk             (clk),
    .rst_n           (rst_n),
    .req_valid_i     (req_valid_i),
    .sg_sel_i        (sg_sel),
    .pte_req_ready_i (pte_req_ready_i),
    .pte_rsp_valid_i (pte_rsp_valid_i),
    .req_ready_o     (req_ready_o),
    .pte_req_valid_o (pte_req_valid_o),
    .fire_imm_o      (fire_imm),
    .fire_sg_o       (fire_sg),
    .pte_done_o      (pte_done)
  );

  // Scatter-gather context held across the fetch
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pte_addr_q <= '0;
      bus_q      <= '0;
    end else if (fire_sg) begin
      pte_addr_q <= pte_addr_nxt;
      bus_q      <= req_addr_i;
    end
  end

  assign pte_req_addr_o = pte_addr_q;

  // Response register
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid_o <= 1'b0;
      rsp_addr_o  <= '0;
      rsp_xlat    <= 1'b0;
    end else begin
      rsp_valid_o <= fire_imm | pte_done;
      if (fire_imm) begin
        rsp_addr_o <= imm_res;
        rsp_xlat   <= any_hit;
      end else if (pte_done) begin
        rsp_addr_o <= sg_res;
        rsp_xlat   <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/dwx_xlate_chk.sv
module dwx_xlate_chk
  import dwx_pkg::*;
#(
  parameter int unsigned NUM_WIN = 4,
  parameter int unsigned PHYS_AW = 34
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_ready_o,
  input logic               pte_req_valid_o,
  input logic               pte_req_ready_i,
  input logic [ADDR_W-1:0]  pte_req_addr_o,
  input logic               rsp_valid_o,
  input logic [ADDR_W-1:0]  rsp_addr_o,
  input logic               rsp_xlat,
  input logic               fire_imm,
  input logic               fire_sg,
  input logic               pte_done,
  input logic [NUM_WIN-1:0] win_grant,
  input logic [NUM_WIN-1:0] win_match,
  input logic [NUM_WIN-1:0] win_en
);

  AST_GRANT_IS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    (win_grant & ~(win_match & win_en)) == '0); // R1

  AST_GRANT_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
    win_grant != '0 |-> ((win_grant - NUM_WIN'(1)) & win_match & win_en) == '0); // R1

  AST_NO_DISABLED_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    (win_grant & ~win_en) == '0); // R3

  AST_PTE_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    pte_req_valid_o |-> pte_req_addr_o[2:0] == 3'b000); // R5

  AST_PTE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    pte_req_valid_o && !pte_req_ready_i |=> pte_req_valid_o && $stable(pte_req_addr_o)); // R5

  AST_XLAT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid_o && rsp_xlat |-> rsp_addr_o[ADDR_W-1:PHYS_AW] == '0); // R7

  AST_IMM_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    fire_imm |=> rsp_valid_o); // R9

  AST_SG_ISSUES: assert property (@(posedge clk) disable iff (!rst_n)
    fire_sg |=> pte_req_valid_o && !req_ready_o); // R9

  AST_RSP_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid_o |-> $past(fire_imm || pte_done)); // R10

  AST_BUSY_DURING_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    pte_req_valid_o |-> !req_ready_o); // R10

endmodule

bind dwx_xlate dwx_xlate_chk #(.NUM_WIN(NUM_WIN), .PHYS_AW(PHYS_AW)) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .req_ready_o     (req_ready_o),
  .pte_req_valid_o (pte_req_valid_o),
  .pte_req_ready_i (pte_req_ready_i),
  .pte_req_addr_o  (pte_req_addr_o),
  .rsp_valid_o     (rsp_valid_o),
  .rsp_addr_o      (rsp_addr_o),
  .rsp_xlat        (rsp_xlat),
  .fire_imm        (fire_imm),
  .fire_sg         (fire_sg),
  .pte_done        (pte_done),
  .win_grant       (win_grant),
  .win_match       (win_match),
  .win_en          (win_en)
);

// File: tb/dwx_xlate_test.sv
module dwx_xlate_test;

  localparam int NW = 4;
  localparam int AW = 64;
  localparam int PA = 34;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic              rst_n;
  logic [NW*AW-1:0]  win_base_i, win_mask_i, win_xbase_i;
  logic              req_valid_i, req_ready_o;
  logic [AW-1:0]     req_addr_i;
  logic              rsp_valid_o;
  logic [AW-1:0]     rsp_addr_o;
  logic              pte_req_valid_o, pte_req_ready_i;
  logic [AW-1:0]     pte_req_addr_o;
  logic              pte_rsp_valid_i;
  logic [AW-1:0]     pte_rsp_data_i;

  logic [AW-1:0] base [NW];
  logic [AW-1:0] mask [NW];
  logic [AW-1:0] xb   [NW];

  for (genvar g = 0; g < NW; g++) begin : g_pack
    assign win_base_i[g*AW +: AW]  = base[g];
    assign win_mask_i[g*AW +: AW]  = mask[g];
    assign win_xbase_i[g*AW +: AW] = xb[g];
  end

  dwx_xlate #(.NUM_WIN(NW), .PHYS_AW(PA)) uut (
    .clk(clk), .rst_n(rst_n),
    .win_base_i(win_base_i), .win_mask_i(win_mask_i), .win_xbase_i(win_xbase_i),
    .req_valid_i(req_valid_i), .req_ready_o(req_ready_o), .req_addr_i(req_addr_i),
    .rsp_valid_o(rsp_valid_o), .rsp_addr_o(rsp_addr_o),
    .pte_req_valid_o(pte_req_valid_o), .pte_req_ready_i(pte_req_ready_i),
    .pte_req_addr_o(pte_req_addr_o),
    .pte_rsp_valid_i(pte_rsp_valid_i), .pte_rsp_data_i(pte_rsp_data_i)
  );

  typedef struct {
    logic [AW-1:0] addr;
    bit            sg;
    longint        cyc;
    string         tag;
  } item_t;

  item_t         exp_q[$];
  logic [AW-1:0] pte_q[$];
  longint        sgc_q[$];
  int            checks = 0;
  int            fails  = 0;
  longint        cyc    = 0;
  bit            done   = 0;
  logic [63:0]   rs     = 64'h9E37_79B9_7F4A_7C15;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(bit ok, string req, logic [AW-1:0] act, logic [AW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] rnd();
    rs = rs ^ (rs << 13);
    rs = rs ^ (rs >> 7);
    rs = rs ^ (rs << 17);
    return rs;
  endfunction

  // R2: bitwise compare over 31:20, skipping bits whose mask bit is 1
  function automatic bit m_hit(logic [AW-1:0] bus, logic [AW-1:0] b, logic [AW-1:0] m);
    for (int k = 20; k <= 31; k++)
      if (!m[k] && bus[k] != b[k]) return 0;
    return 1;
  endfunction

  // R1/R3: first enabled hit from index 0
  function automatic int m_pick(logic [AW-1:0] bus);
    for (int w = 0; w < NW; w++)
      if (base[w][0] && m_hit(bus, base[w], mask[w])) return w;
    return -1;
  endfunction

  // R4 and R7, bit by bit
  function automatic logic [AW-1:0] m_direct(logic [AW-1:0] bus, logic [AW-1:0] m, logic [AW-1:0] t);
    logic [AW-1:0] r;
    for (int k = 0; k < AW; k++) begin
      if (k >= PA)                         r[k] = 1'b0;
      else if (k < 20 || (k < 32 && m[k])) r[k] = bus[k];
      else                                 r[k] = t[k];
    end
    return r;
  endfunction

  // R5, bit by bit
  function automatic logic [AW-1:0] m_pte(logic [AW-1:0] bus, logic [AW-1:0] m, logic [AW-1:0] t);
    logic [AW-1:0] r;
    for (int k = 0; k < AW; k++) begin
      if (k < 3)       r[k] = 1'b0;
      else if (k < 10) r[k] = bus[k+10];
      else if (k < 22) r[k] = m[k+10] ? bus[k+10] : t[k];
      else             r[k] = t[k];
    end
    return r;
  endfunction

  // R6 and R7
  function automatic logic [AW-1:0] m_sg(logic [AW-1:0] pte, logic [AW-1:0] bus);
    logic [AW-1:0] r;
    for (int k = 0; k < AW; k++) begin
      if (k < 13)      r[k] = bus[k];
      else if (k < PA) r[k] = pte[k-12];
      else             r[k] = 1'b0;
    end
    return r;
  endfunction

  // Table memory content, bit 0 set so that it must be discarded
  function automatic logic [AW-1:0] pte_val(logic [AW-1:0] a);
    return {~a[31:0], a[31:1], 1'b1};
  endfunction

  task automatic send(logic [AW-1:0] bus, string tag);
    item_t it;
    int    w;
    w      = m_pick(bus);
    it.sg  = 0;
    it.tag = tag;
    if (w < 0) begin
      it.addr = bus;
    end else if (base[w][1]) begin
      it.sg   = 1;
      it.addr = m_sg(pte_val(m_pte(bus, mask[w], xb[w])), bus);
      pte_q.push_back(m_pte(bus, mask[w], xb[w]));
    end else begin
      it.addr = m_direct(bus, mask[w], xb[w]);
    end
    req_valid_i = 1'b1;
    req_addr_i  = bus;
    forever begin
      @(negedge clk);
      if (req_ready_o) break;
    end
    @(posedge clk);
    #1;
    req_valid_i = 1'b0;
    it.cyc = cyc;
    exp_q.push_back(it);
  endtask

  task automatic drain();
    wait (exp_q.size() == 0 && pte_q.size() == 0);
    repeat (3) @(posedge clk);
    #1;
  endtask

  task automatic rand_run(int n);
    for (int i = 0; i < n; i++) begin
      logic [63:0] r;
      r = rnd();
      case (r[2:0])
        3'd0, 3'd1: r[31:24] = 8'h40;
        3'd2:       r[31:20] = 12'hC00;
        default: ;
      endcase
      send(r, "R4/R6/R8 random");
    end
  endtask

  // Monitor: scoreboard compare of each response
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && rsp_valid_o) begin
        if (exp_q.size() == 0) begin
          chk(0, "R10 unexpected response", rsp_addr_o, '0);
        end else begin
          item_t  it;
          longint ec;
          it = exp_q.pop_front();
          chk(rsp_addr_o == it.addr, it.tag, rsp_addr_o, it.addr);
          ec = it.sg ? ((sgc_q.size() != 0) ? sgc_q.pop_front() : -1) : it.cyc;
          chk(cyc == ec, "R9 latency", 64'(cyc), 64'(ec));
        end
      end
    end
  end

  // Table memory responder with varying delays
  initial begin
    int nsg = 0;
    pte_req_ready_i = 1'b0;
    forever begin
      @(negedge clk);
      if (rst_n && pte_req_valid_o) begin
        logic [AW-1:0] a, e;
        e = (pte_q.size() != 0) ? pte_q.pop_front() : '1;
        chk(!req_ready_o, "R10 ready low during fetch", 64'(req_ready_o), 64'd0);
        chk(pte_req_addr_o == e, "R5 entry address", pte_req_addr_o, e);
        repeat (nsg % 3) @(negedge clk);
        chk(pte_req_addr_o == e, "R5 entry address held", pte_req_addr_o, e);
        pte_req_ready_i = 1'b1;
        a = pte_req_addr_o;
        @(negedge clk);
        pte_req_ready_i = 1'b0;
        repeat ((nsg + 1) % 4) @(negedge clk);
        pte_rsp_data_i  = pte_val(a);
        pte_rsp_valid_i = 1'b1;
        @(posedge clk);
        #1;
        sgc_q.push_back(cyc);
        pte_rsp_valid_i = 1'b0;
        nsg++;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n           = 1'b0;
    req_valid_i     = 1'b0;
    req_addr_i      = '0;
    pte_rsp_valid_i = 1'b0;
    pte_rsp_data_i  = '0;
    for (int w = 0; w < NW; w++) begin
      base[w] = '0; mask[w] = '0; xb[w] = '0;
    end
    repeat (3) @(posedge clk);
    #1;
    chk(req_ready_o == 1'b1,     "R11 ready after reset", 64'(req_ready_o), 64'd1);
    chk(rsp_valid_o == 1'b0,     "R11 no response",       64'(rsp_valid_o), 64'd0);
    chk(pte_req_valid_o == 1'b0, "R11 no entry read",     64'(pte_req_valid_o), 64'd0);
    rst_n = 1'b1;
    @(posedge clk);
    #1;

    // Config A: overlapping windows, one scatter-gather, one disabled
    base[0] = 64'h0000_0000_8000_0001; mask[0] = 64'h0000_0000_3FF0_0000; xb[0] = 64'h0000_0002_4000_0000;
    base[1] = 64'h0000_0000_4000_0003; mask[1] = 64'h0000_0000_00F0_0000; xb[1] = 64'hF000_0001_2345_6000;
    base[2] = 64'h0000_0000_C000_0002; mask[2] = 64'h0;                   xb[2] = 64'h0000_0001_1110_0000;
    base[3] = 64'h0000_0000_8000_0001; mask[3] = 64'h0000_0000_7FF0_0000; xb[3] = 64'hFFFF_FFF3_C000_0000;
    #1;
    send(64'h0000_0000_8765_4321, "R1 lowest window wins");
    send(64'hFFFF_0000_8765_4321, "R7 upper bits dropped");
    send(64'h0000_0000_C001_2345, "R3 disabled window skipped");
    send(64'h0000_0000_E123_4567, "R7 direct through window 3");
    send(64'h0000_0000_40AB_CDEF, "R6 scatter-gather result");
    send(64'h0000_0000_8000_0000, "R10 direct after scatter-gather");
    send(64'h0000_0000_41AB_CDEF, "R2 compare bit differs");
    send(64'h0000_0001_0000_1234, "R8 pass-through");
    send(64'hABCD_0000_40F0_1FFF, "R6 scatter-gather with masked bits");
    rand_run(60);
    drain();

    // Stray entry response while idle must change nothing
    @(negedge clk);
    pte_rsp_data_i  = 64'hDEAD_BEEF_0000_0001;
    pte_rsp_valid_i = 1'b1;
    @(negedge clk);
    pte_rsp_valid_i = 1'b0;
    chk(rsp_valid_o == 1'b0, "R10 stray entry response ignored", 64'(rsp_valid_o), 64'd0);
    chk(req_ready_o == 1'b1, "R10 ready kept after stray",      64'(req_ready_o), 64'd1);
    @(posedge clk);
    #1;

    // Config B: window 0 disabled, window 1 catches everything
    base[0] = 64'h0000_0000_0000_0002; mask[0] = 64'h0000_0000_FFF0_0000;
    base[1] = 64'h0000_0000_0000_0003; mask[1] = 64'h0000_0000_FFF0_0000; xb[1] = 64'h0000_00AB_CDE0_0000;
    #1;
    send(64'h0000_0000_1234_5678, "R3 catch-all behind disabled window");
    rand_run(30);
    drain();

    // Config C: everything disabled
    for (int w = 0; w < NW; w++) base[w][0] = 1'b0;
    #1;
    send(64'hFEDC_BA98_8765_4321, "R8 all windows disabled");
    rand_run(20);
    drain();

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule